// File: doc/BRIEF.md
# Strobe-Driven FIFO Buffer with Status Flags

This block is a first-in first-out store for 9-bit words whose depth is a power of two between 2,048 and 65,536 words. It is driven by active-low write and read strobes rather than by enables. All three strobes (write, read and rewind) are sampled by one system clock, and their edges are detected in that clock domain. A word is stored when the write strobe rises. A word is presented on the output bus while the read strobe is low, and the bus is released when the strobe rises. Empty, full and more-than-half-full flags report the occupancy.

Two boundary behaviours are defined. The first is read flow-through: a read strobe that falls on an empty buffer waits, and the word written next is presented without a new falling edge. The second is write flow-through: a write strobe that falls on a full buffer waits, and its rising edge loads the word once a read has freed a location. A rewind strobe moves the read position back to the first location, so the data written since reset can be sent again.

Two state machines do the work. The write machine has these states: `W_IDLE` moves to `W_ARMED` on a falling write strobe with space free, and to `W_STALLED` on a falling write strobe while full. `W_STALLED` moves to `W_ARMED` when space appears. `W_ARMED` and `W_STALLED` both return to `W_IDLE` on a rising strobe, and the word is stored only if the buffer is not full. The read machine has these states: `R_IDLE` moves to `R_SHOW` on a falling read strobe with data present, and to `R_WAIT` on a falling read strobe while empty. `R_WAIT` moves to `R_SHOW` when a word arrives. `R_SHOW` returns to `R_IDLE` on a rising strobe and consumes the word. `R_WAIT` returns to `R_IDLE` on a rising strobe and consumes nothing.

Top module: `strobe_fifo`

## Requirements
- R1: After reset is asserted, empty is 1, full is 0, half_full is 0 and q_oe is 0, and the store holds no words.
- R2: A rising edge on wr_n while the buffer is not full stores the word on din (sampled in the cycle of the rising edge). Words leave the buffer in the order they were stored.
- R3: A falling edge on rd_n with data present sets q_oe to 1 and shows the oldest word on q_bus one clock later. The next rising edge on rd_n sets q_oe to 0 and removes that word.
- R4: A read strobe on an empty buffer with no write during it leaves q_oe at 0 and removes nothing.
- R5: A rising edge on wr_n while full stores nothing and does not change the contents.
- R6: If rd_n is held low on an empty buffer and a word is written, empty goes to 0 and that word is shown on q_bus with q_oe at 1, without a new falling edge on rd_n. When rd_n rises, the word is consumed and empty returns to 1.
- R7: If wr_n falls while full and a read then frees one location, full goes to 0. The rising edge of that same wr_n pulse then stores its word, and full returns to 1.
- R8: half_full is 1 exactly when the occupancy is greater than DEPTH/2.
- R9: full is 1 exactly when the occupancy equals DEPTH, and the occupancy never exceeds DEPTH.
- R10: A falling edge on rt_n while no read strobe is active moves the read position to the first location. The write position is unchanged, so every word stored since reset is read again in order.
- R11: A falling edge on rt_n while a word is being shown is ignored, and the read position is kept.
- R12: A read completion and a write completion in the same clock cycle both take effect when the buffer is neither empty nor full before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every strobe |
| rst_n | input | 1 | Active-low asynchronous reset of pointers and machines |
| wr_n | input | 1 | Active-low write strobe; its rising edge stores din |
| rd_n | input | 1 | Active-low read strobe; low shows a word, its rise consumes it |
| rt_n | input | 1 | Active-low rewind strobe; its falling edge restarts reading at location zero |
| din | input | WIDTH | Word to be stored |
| q_bus | output | WIDTH | Output word; high-impedance while q_oe is 0 |
| q_oe | output | 1 | High while q_bus is driven |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| half_full | output | 1 | Occupancy is greater than DEPTH/2 |

## Verification
A read completion and a write completion can fall in the same clock cycle, so both pointers move on the same edge. The bench provokes this by lowering both strobes together over a partly filled buffer and then raising them together. It then checks that the presented word was the oldest one, that the occupancy did not change, and that the new word comes out after the remaining old one. The boundary forms of the same collision are checked as well. A write that finishes while the read machine waits on an empty buffer must be presented without a new read edge. A read that finishes while a write waits on a full buffer must let that write's rising edge store its word.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    typedef enum logic [1:0] {
        W_IDLE    = 2'd0,
        W_ARMED   = 2'd1,
        W_STALLED = 2'd2
    } wr_state_t;

    typedef enum logic [1:0] {
        R_IDLE = 2'd0,
        R_SHOW = 2'd1,
        R_WAIT = 2'd2
    } rd_state_t;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_n;

    for (genvar i = 0; i < N; i++) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_n[i] <= 1'b1;
            end else begin
                prev_n[i] <= strobe_n[i];
            end
        end

        assign rise[i] = strobe_n[i] & ~prev_n[i];
        assign fall[i] = ~strobe_n[i] & prev_n[i];
    end

endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
    import strobe_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fall,
    input  logic wr_rise,
    input  logic full,
    output logic wr_go
);
    wr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (wr_fall) begin
                    state_d = full ? W_STALLED : W_ARMED;
                end
            end
            W_ARMED: begin
                if (wr_rise) begin
                    state_d = W_IDLE;
                end
            end
            W_STALLED: begin
                if (wr_rise) begin
                    state_d = W_IDLE;
                end else if (!full) begin
                    state_d = W_ARMED;
                end
            end
            default: state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        wr_go = 1'b0;
        unique case (state_q)
            W_IDLE:    wr_go = 1'b0;
            W_ARMED:   wr_go = wr_rise && !full;
            W_STALLED: wr_go = wr_rise && !full;
            default:   wr_go = 1'b0;
        endcase
    end

endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
    import strobe_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_fall,
    input  logic rd_rise,
    input  logic empty,
    output logic rd_go,
    output logic show,
    output logic idle
);
    rd_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE: begin
                if (rd_fall) begin
                    state_d = empty ? R_WAIT : R_SHOW;
                end
            end
            R_SHOW: begin
                if (rd_rise) begin
                    state_d = R_IDLE;
                end
            end
            R_WAIT: begin
                if (rd_rise) begin
                    state_d = R_IDLE;
                end else if (!empty) begin
                    state_d = R_SHOW;
                end
            end
            default: state_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_go = 1'b0;
        show  = 1'b0;
        idle  = 1'b0;
        unique case (state_q)
            R_IDLE: idle = 1'b1;
            R_SHOW: begin
                show  = 1'b1;
                rd_go = rd_rise;
            end
            R_WAIT: ;
            default: idle = 1'b1;
        endcase
    end

endmodule

// File: rtl/fifo_ptrs.sv
module fifo_ptrs #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic          rd_go,
    input  logic          rt_go,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   count,
    output logic          empty,
    output logic          full,
    output logic          half_full
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] HALF_CNT = {2'b01, {(AW-1){1'b0}}};

    logic [AW:0] wptr_q;
    logic [AW:0] rptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (wr_go) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    // Rewind has priority; the read machine never grants both together.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q <= '0;
        end else if (rt_go) begin
            rptr_q <= '0;
        end else if (rd_go) begin
            rptr_q <= rptr_q + 1'b1;
        end
    end

    assign count     = wptr_q - rptr_q;
    assign empty     = (count == '0);
    assign full      = (count == FULL_CNT);
    assign half_full = (count > HALF_CNT);
    assign waddr     = wptr_q[AW-1:0];
    assign raddr     = rptr_q[AW-1:0];

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int WIDTH = 9,
    parameter int AW    = 11
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int WIDTH      = 9,
    parameter int DEPTH_LOG2 = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rt_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q_bus,
    output logic             q_oe,
    output logic             empty,
    output logic             full,
    output logic             half_full
);
    localparam int AW      = DEPTH_LOG2;
    localparam int STROBES = 3;
    localparam int IDX_WR  = 0;
    localparam int IDX_RD  = 1;
    localparam int IDX_RT  = 2;

    logic [STROBES-1:0] strobe_n;
    logic [STROBES-1:0] s_rise;
    logic [STROBES-1:0] s_fall;
    logic               wr_go;
    logic               rd_go;
    logic               rt_go;
    logic               rd_show;
    logic               rd_idle;
    logic [AW-1:0]      waddr;
    logic [AW-1:0]      raddr;
    logic [AW:0]        count;
    logic [WIDTH-1:0]   rdata;

    assign strobe_n = {rt_n, rd_n, wr_n};

    strobe_edge #(.N(STROBES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    fifo_wr_ctrl u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fall (s_fall[IDX_WR]),
        .wr_rise (s_rise[IDX_WR]),
        .full    (full),
        .wr_go   (wr_go)
    );

    fifo_rd_ctrl u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_fall (s_fall[IDX_RD]),
        .rd_rise (s_rise[IDX_RD]),
        .empty   (empty),
        .rd_go   (rd_go),
        .show    (rd_show),
        .idle    (rd_idle)
    );

    // Rewind is honoured only while no read strobe is active.
    assign rt_go = s_fall[IDX_RT] && rd_idle;

    fifo_ptrs #(.AW(AW)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .rt_go     (rt_go),
        .waddr     (waddr),
        .raddr     (raddr),
        .count     (count),
        .empty     (empty),
        .full      (full),
        .half_full (half_full)
    );

    fifo_store #(.WIDTH(WIDTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (wr_go),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign q_oe  = rd_show;
    assign q_bus = rd_show ? rdata : {WIDTH{1'bz}};

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int AW = 11
) (
    input logic        clk,
    input logic        rst_n,
    input logic [AW:0] count,
    input logic        empty,
    input logic        full,
    input logic        half_full,
    input logic        q_oe,
    input logic        rd_go,
    input logic        rt_go
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !q_oe) |=> !rd_go); // R4

    AST_BUS_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        q_oe |-> !empty); // R3

    AST_RELEASE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> !q_oe); // R3

    AST_FULL_ABOVE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (half_full && !empty)); // R8

    AST_NO_REWIND_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        q_oe |-> !rt_go); // R11

endmodule

bind strobe_fifo strobe_fifo_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .empty     (empty),
    .full      (full),
    .half_full (half_full),
    .q_oe      (q_oe),
    .rd_go     (rd_go),
    .rt_go     (rt_go)
);

// File: tb/tb_strobe_fifo.sv
`timescale 1ns/1ps
module tb_strobe_fifo;
    localparam int W     = 9;
    localparam int AWB   = 11;
    localparam int DEPTH = 1 << AWB;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         rt_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] q_bus;
    logic         q_oe;
    logic         empty;
    logic         full;
    logic         half_full;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    strobe_fifo #(.WIDTH(W), .DEPTH_LOG2(AWB)) dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .q_bus(q_bus), .q_oe(q_oe), .empty(empty), .full(full),
        .half_full(half_full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int i);
        return W'((i * 7 + 3) & ((1 << W) - 1));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_word(input logic [W-1:0] d);
        @(negedge clk);
        wr_n = 1'b0; din = d;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_word(output logic [W-1:0] d, output logic oe);
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        d = q_bus; oe = q_oe;
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
        chk(full == 1'b0 && half_full == 1'b0, "R1", "full|half after reset",
            int'({full, half_full}), 0);
        chk(q_oe == 1'b0, "R1", "bus released after reset", int'(q_oe), 0);
    endtask

    task automatic t_order();
        logic [W-1:0] d;
        logic oe;
        do_reset();
        for (int i = 0; i < 3; i++) wr_word(pat(i + 100));
        for (int i = 0; i < 3; i++) begin
            rd_word(d, oe);
            chk(oe && d == pat(i + 100), "R2", "read order", int'(d), int'(pat(i + 100)));
        end
        chk(q_oe == 1'b0, "R3", "bus released after rise", int'(q_oe), 0);
        chk(empty == 1'b1, "R3", "empty after draining", int'(empty), 1);
    endtask

    task automatic t_read_empty();
        logic [W-1:0] d;
        logic oe;
        do_reset();
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk);
        chk(q_oe == 1'b0, "R4", "no drive on empty read", int'(q_oe), 0);
        rd_n = 1'b1;
        @(negedge clk);
        chk(empty == 1'b1, "R4", "still empty", int'(empty), 1);
        wr_word(9'h1AB);
        rd_word(d, oe);
        chk(oe && d == 9'h1AB, "R4", "pointer unmoved by empty read", int'(d), 'h1AB);
    endtask

    task automatic t_read_flow();
        do_reset();
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); wr_n = 1'b0; din = 9'h0C3;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        chk(empty == 1'b0, "R6", "empty pulse deasserted", int'(empty), 0);
        @(negedge clk);
        chk(q_oe && q_bus == 9'h0C3, "R6", "flow-through word shown", int'(q_bus), 'h0C3);
        rd_n = 1'b1;
        @(negedge clk);
        chk(empty == 1'b1 && q_oe == 1'b0, "R6", "empty reasserted, bus released",
            int'({empty, q_oe}), 2);
    endtask

    task automatic t_full_flow();
        logic [W-1:0] d;
        logic oe;
        int bad;
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(pat(i));
            if (i + 1 == DEPTH / 2)
                chk(half_full == 1'b0, "R8", "half at DEPTH/2", int'(half_full), 0);
            if (i + 1 == DEPTH / 2 + 1)
                chk(half_full == 1'b1, "R8", "half above DEPTH/2", int'(half_full), 1);
            if (i + 1 == DEPTH - 1)
                chk(full == 1'b0, "R9", "not full at DEPTH-1", int'(full), 0);
        end
        chk(full == 1'b1, "R9", "full at DEPTH", int'(full), 1);
        wr_word(9'h055);
        chk(full == 1'b1, "R5", "still full after ignored write", int'(full), 1);
        @(negedge clk); wr_n = 1'b0; din = 9'h1EE;
        @(negedge clk);
        rd_word(d, oe);
        chk(oe && d == pat(0), "R7", "word read from full", int'(d), int'(pat(0)));
        chk(full == 1'b0, "R7", "full dropped by read", int'(full), 0);
        wr_n = 1'b1;
        @(negedge clk);
        chk(full == 1'b1, "R7", "full after flow-through write", int'(full), 1);
        bad = 0;
        for (int i = 1; i <= DEPTH; i++) begin
            logic [W-1:0] e;
            e = (i == DEPTH) ? 9'h1EE : pat(i);
            rd_word(d, oe);
            if (!(oe && d == e)) begin
                if (bad == 0) chk(1'b0, "R5", "drain after full", int'(d), int'(e));
                bad++;
            end
        end
        if (bad == 0) chk(1'b1, "R5", "drain after full", 0, 0);
        chk(empty == 1'b1, "R7", "empty after drain", int'(empty), 1);
    endtask

    task automatic t_rewind();
        logic [W-1:0] d;
        logic oe;
        do_reset();
        for (int i = 0; i < 5; i++) wr_word(pat(i + 40));
        for (int i = 0; i < 2; i++) rd_word(d, oe);
        @(negedge clk); rt_n = 1'b0;
        @(negedge clk); rt_n = 1'b1;
        @(negedge clk);
        wr_word(pat(45));
        for (int i = 0; i < 6; i++) begin
            rd_word(d, oe);
            chk(oe && d == pat(i + 40), "R10", "replay after rewind", int'(d), int'(pat(i + 40)));
        end
        chk(empty == 1'b1, "R10", "empty after replay", int'(empty), 1);
    endtask

    task automatic t_rewind_busy();
        logic [W-1:0] d;
        logic oe;
        do_reset();
        for (int i = 0; i < 3; i++) wr_word(pat(i + 60));
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); rt_n = 1'b0;
        @(negedge clk); rt_n = 1'b1;
        @(negedge clk);
        chk(q_oe && q_bus == pat(60), "R11", "word held during rewind", int'(q_bus), int'(pat(60)));
        rd_n = 1'b1;
        @(negedge clk);
        rd_word(d, oe);
        chk(oe && d == pat(61), "R11", "rewind ignored in read", int'(d), int'(pat(61)));
    endtask

    task automatic t_same_cycle();
        logic [W-1:0] d;
        logic oe;
        do_reset();
        wr_word(9'h011);
        wr_word(9'h022);
        @(negedge clk); rd_n = 1'b0; wr_n = 1'b0; din = 9'h033;
        @(negedge clk);
        chk(q_oe && q_bus == 9'h011, "R12", "oldest shown", int'(q_bus), 'h011);
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        chk(q_oe == 1'b0 && empty == 1'b0, "R12", "released, not empty",
            int'({q_oe, empty}), 0);
        rd_word(d, oe);
        chk(oe && d == 9'h022, "R12", "second word", int'(d), 'h022);
        rd_word(d, oe);
        chk(oe && d == 9'h033, "R12", "word written in same cycle", int'(d), 'h033);
        chk(empty == 1'b1, "R12", "empty at end", int'(empty), 1);
    endtask

    task automatic t_reset_mid();
        wr_word(9'h0AA);
        wr_word(9'h0BB);
        do_reset();
        chk(empty == 1'b1 && full == 1'b0, "R1", "reset clears occupancy",
            int'({empty, full}), 2);
    endtask

    initial begin
        t_reset();
        t_order();
        t_read_empty();
        t_read_flow();
        t_same_cycle();
        t_rewind();
        t_rewind_busy();
        t_full_flow();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule